// File: doc/BRIEF.md
# Mask-Driven Bit Partition Unit

The unit splits one data word into two groups under the control of a per-bit selector mask. Data bits whose mask bit is set are packed into the upper half of the result. Data bits whose mask bit is clear are packed into the lower half. Within each half the bits keep the order they had in the input word, with the most significant input bit first. The partition is stable in both directions. It is neither a fixed multiplexer nor a shifter.

Each half is filled by its own prefix chain. A running count, carried from the top bit downwards, gives each selected bit its rank among the bits of its class. The bit with rank k lands in slot k of the half, counted from the half's most significant position. Bits of the other class are passed over. A legal mask has exactly half of its bits set. For any other mask the unit flags an error and still returns a defined partial packing.

Inputs are captured when `in_valid` is high. The result is presented, registered, one clock later.

Top module: `bitpart_unit`

## Requirements
- R1: Every data bit whose mask bit is 1 appears in the upper nibble, out_data[7:4]. The order is kept, so the first such bit found from the MSB down sits at out_data[7].
- R2: Every data bit whose mask bit is 0 appears in the lower nibble, out_data[3:0]. The order is kept, so the first such bit found from the MSB down sits at out_data[3].
- R3: Take data bits A..H, with A as the MSB, and mask 8'b1010_1010. The result is A C E G B D F H. With any legal mask, the result has as many ones as the data word.
- R4: mask_err is 1, alongside the result of that input, exactly when the captured mask does not have four bits set. Otherwise it is 0.
- R5: With an illegal mask, each nibble is still filled from its MSB down in input order. Bits beyond the fourth of a class are dropped, and unfilled positions are 0.
- R6: Each cycle with in_valid high produces out_valid high in the next cycle, together with its result. Back-to-back inputs give back-to-back results.
- R7: In a cycle after in_valid was low, out_valid is 0, and out_data and mask_err keep their previous values, whatever the data and mask inputs do.
- R8: A synchronous active-high reset clears out_valid, out_data and mask_err to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for in_data and in_mask |
| in_data | input | 8 | Word to partition |
| in_mask | input | 8 | Selector mask: 1 sends the bit up, 0 sends it down |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 8 | Partitioned word |
| mask_err | output | 1 | Captured mask did not have exactly four ones |

## Verification
Some properties are checked on every cycle:
- the one-cycle relation between in_valid and out_valid;
- the holding of result and flag while idle;
- the agreement of mask_err with the population count of the captured mask;
- the preservation of the number of ones for legal masks, and the fact that the count never grows for illegal ones.

These checks cannot show that each bit reaches the right slot. The bench's scenarios do that. They compare every output against an independent reference for all seventy legal masks with random data, for the worked example, and for illegal masks with too few or too many ones. They also drive back-to-back traffic and idle stretches in which the inputs change.

// File: rtl/bitpart_pkg.sv
package bitpart_pkg;

    // Which class of mask bit a gather chain collects.
    typedef enum logic {
        CLASS_CLEAR = 1'b0,
        CLASS_SET   = 1'b1
    } bit_class_e;

endpackage

// File: rtl/bitpart_gather.sv
module bitpart_gather
    import bitpart_pkg::*;
#(
    parameter int         W     = 8,
    parameter int         SLOTS = 4,
    parameter bit_class_e POL   = CLASS_SET,
    localparam int        CW    = $clog2(W + 1)
) (
    input  logic [W-1:0]     data,
    input  logic [W-1:0]     mask,
    output logic [SLOTS-1:0] packed_bits,
    output logic [CW-1:0]    hits
);

    logic [W-1:0]  match;
    logic [CW-1:0] rank [W+1];

    // Prefix chain from the MSB downwards: rank[i] counts the matches above bit i.
    assign rank[W] = '0;

    for (genvar i = W - 1; i >= 0; i--) begin : g_chain
        assign match[i] = (mask[i] == logic'(POL));
        assign rank[i]  = rank[i+1] + CW'(match[i]);
    end

    assign hits = rank[0];

    // Slot s, counted from the MSB side of the group, takes the bit whose rank is s.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [W-1:0] pick;
        for (genvar i = 0; i < W; i++) begin : g_pick
            assign pick[i] = match[i] && (rank[i+1] == CW'(s)) && data[i];
        end
        assign packed_bits[SLOTS-1-s] = |pick;
    end

endmodule

// File: rtl/bitpart_unit.sv
module bitpart_unit
    import bitpart_pkg::*;
#(
    parameter int W = 8,
    localparam int HALF = W / 2,
    localparam int CW   = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic [W-1:0] in_mask,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         mask_err
);

    typedef struct packed {
        logic         vld;
        logic         err;
        logic [W-1:0] res;
    } state_t;

    state_t st_d, st_q;

    logic [HALF-1:0] grp_bits [2];
    logic [CW-1:0]   grp_hits [2];

    for (genvar g = 0; g < 2; g++) begin : g_class
        bitpart_gather #(
            .W     (W),
            .SLOTS (HALF),
            .POL   (bit_class_e'(g))
        ) gather_i (
            .data        (in_data),
            .mask        (in_mask),
            .packed_bits (grp_bits[g]),
            .hits        (grp_hits[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (in_valid) begin
            st_d.vld = 1'b1;
            st_d.res = {grp_bits[1], grp_bits[0]};
            st_d.err = (grp_hits[1] != CW'(HALF)) || (grp_hits[0] != CW'(W - HALF));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.res;
    assign mask_err  = st_q.err;

endmodule

// File: rtl/bitpart_unit_chk.sv
module bitpart_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] in_data,
    input logic [W-1:0] in_mask,
    input logic         out_valid,
    input logic [W-1:0] out_data,
    input logic         mask_err
);

    AST_VALID_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid)); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> ($stable(out_data) && $stable(mask_err))); // R7

    AST_ERR_FROM_MASK: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (mask_err == ($countones($past(in_mask)) != W / 2))); // R4

    AST_ONES_KEPT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !mask_err) |-> ($countones(out_data) == $countones($past(in_data)))); // R3

    AST_PARTIAL_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_data) <= $countones($past(in_data)))); // R5

endmodule

bind bitpart_unit bitpart_unit_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_mask   (in_mask),
    .out_valid (out_valid),
    .out_data  (out_data),
    .mask_err  (mask_err)
);

// File: tb/bitpart_unit_tb_top.sv
module bitpart_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_data;
    logic [7:0] in_mask;
    logic       out_valid;
    logic [7:0] out_data;
    logic       mask_err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bitpart_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_mask   (in_mask),
        .out_valid (out_valid),
        .out_data  (out_data),
        .mask_err  (mask_err)
    );

    // Reference: {err, result}, built from R1, R2, R4 and R5.
    function automatic logic [8:0] ref_part(input logic [7:0] d, input logic [7:0] m);
        logic [3:0] hi = '0;
        logic [3:0] lo = '0;
        int nh = 0;
        int nl = 0;
        for (int i = 7; i >= 0; i--) begin
            if (m[i]) begin
                if (nh < 4) hi[3-nh] = d[i];
                nh++;
            end else begin
                if (nl < 4) lo[3-nl] = d[i];
                nl++;
            end
        end
        return {(nh != 4), hi, lo};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on the falling edge; the result is sampled on the next falling edge.
    task automatic apply(input logic [7:0] d, input logic [7:0] m);
        in_valid = 1'b1;
        in_data  = d;
        in_mask  = m;
        @(negedge clk);
    endtask

    task automatic expect_result(input string req, input logic [7:0] d, input logic [7:0] m);
        logic [8:0] r = ref_part(d, m);
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " data"}, {24'd0, out_data}, {24'd0, r[7:0]});
        check({req, " err"}, {31'd0, mask_err}, {31'd0, r[8]});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = 8'hFF;
        in_mask = 8'hF0;
        repeat (3) @(negedge clk);
        check("R8 out_valid", {31'd0, out_valid}, 32'd0);
        check("R8 out_data", {24'd0, out_data}, 32'd0);
        check("R8 mask_err", {31'd0, mask_err}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_example();
        // A..H = 1,1,0,0,1,0,1,0 -> A C E G = 1 0 1 1, B D F H = 1 0 0 0
        apply(8'b1100_1010, 8'b1010_1010);
        in_valid = 1'b0;
        check("R3 example", {24'd0, out_data}, {24'd0, 8'b1011_1000});
        check("R3 example err", {31'd0, mask_err}, 32'd0);
        // A single set bit in the data, placed at A, then at H
        apply(8'b1000_0000, 8'b0000_1111);
        in_valid = 1'b0;
        check("R2 msb of zero class", {24'd0, out_data}, {24'd0, 8'b0000_1000});
        apply(8'b0000_0001, 8'b0000_1111);
        in_valid = 1'b0;
        check("R1 lsb of one class", {24'd0, out_data}, {24'd0, 8'b0001_0000});
    endtask

    task automatic t_all_legal();
        for (int m = 0; m < 256; m++) begin
            if ($countones(m[7:0]) == 4) begin
                logic [7:0] d = 8'($urandom);
                apply(d, m[7:0]);
                expect_result("R1 R2 legal mask", d, m[7:0]);
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_illegal();
        logic [7:0] masks [6] = '{8'h00, 8'hFF, 8'h01, 8'hF8, 8'h7F, 8'h81};
        foreach (masks[k]) begin
            logic [7:0] d = 8'($urandom) | 8'h81;
            apply(d, masks[k]);
            expect_result("R4 R5 illegal mask", d, masks[k]);
        end
        in_valid = 1'b0;
        @(negedge clk);
        // All ones in data, only two set mask bits -> hi 1100, lo 1111
        apply(8'hFF, 8'b0100_0100);
        in_valid = 1'b0;
        check("R5 partial fill", {24'd0, out_data}, {24'd0, 8'b1100_1111});
        check("R4 partial err", {31'd0, mask_err}, 32'd1);
    endtask

    task automatic t_idle_hold();
        apply(8'h5A, 8'hC3);
        in_valid = 1'b0;
        begin
            logic [8:0] r = ref_part(8'h5A, 8'hC3);
            for (int c = 0; c < 4; c++) begin
                in_data = 8'($urandom);
                in_mask = 8'($urandom);
                @(negedge clk);
                check("R7 idle valid low", {31'd0, out_valid}, 32'd0);
                check("R7 idle data held", {24'd0, out_data}, {24'd0, r[7:0]});
                check("R7 idle err held", {31'd0, mask_err}, {31'd0, r[8]});
            end
        end
    endtask

    task automatic t_back_to_back();
        apply(8'h3C, 8'hF0);
        expect_result("R6 first", 8'h3C, 8'hF0);
        apply(8'hA5, 8'h0F);
        expect_result("R6 second", 8'hA5, 8'h0F);
        apply(8'hE7, 8'h07);
        expect_result("R6 third", 8'hE7, 8'h07);
        in_valid = 1'b0;
        @(negedge clk);
        check("R6 strobe drops", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_example();
        t_all_legal();
        t_illegal();
        t_idle_hold();
        t_back_to_back();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule